// File: doc/BRIEF.md
# Hardware Task Delay Manager

This peripheral takes over the timekeeping of an operating system. It keeps a system time register that counts every clock cycle and that software can read or overwrite. It also keeps a bank of per-task countdown slots. Software suspends a task by loading its slot with a number of ticks. When that count runs out, the block marks the task in a bitmap of tasks waiting to be woken and raises a level interrupt.

Software reads the bitmap to find the tasks it must make ready, and it acknowledges each woken task by writing the task's index. The interrupt stays high while any task is still waiting to be acknowledged. All control goes through a small word-addressed register bus. Reads return data combinationally in the same cycle, and writes take effect at the clock edge.

The counter width (`CNT_W`, at most 64) and the number of slots (`NUM_TASKS`, 2 to 32) are parameters. The defaults are 64 and 12.

Top module: `task_delay_mgr`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the system time is zero, the high-half shadow is zero, the wake bitmap is zero, irq is low and every staging register is zero.
- R2: The system time grows by one on every clock cycle in which it is not written, and it wraps to zero after 2^CNT_W - 1. Each half reads as a 32-bit word, with the time zero-extended to 64 bits.
- R3: Writing address 1 stages a high word. Writing address 0 then loads the system time with {staged high, written low}, truncated to CNT_W, at that write's edge. Counting resumes from that value on the next cycle.
- R4: Addresses 2 and 3 stage the low and high words of a delay N. Writing a task index to address 4 loads that slot with N. The task's bit in the wake bitmap (address 5, bit i for task i) is first seen N+1 cycles after the loading edge, so a delay of zero shows on the next cycle.
- R5: Loading a slot that is still counting restarts it from the new value, and the old countdown never expires.
- R6: irq is high exactly when the wake bitmap is non-zero, and it stays high until every set bit has been acknowledged.
- R7: A read of address 0 captures the upper 32 bits of the current time into a shadow register. Later reads of address 1 return that shadow, not the live upper bits.
- R8: Writing a task index to address 6 clears only that task's wake bit. An index of NUM_TASKS or more, written to address 6 or address 4, is ignored.
- R9: When an acknowledge and an expiry of the same slot meet in one cycle, the expiry wins and the wake bit stays set.
- R10: Loading a slot leaves its current wake bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address: 0 time low, 1 time high, 2 delay low, 3 delay high, 4 load, 5 wake bitmap, 6 acknowledge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, same cycle |
| irq | output | 1 | Level interrupt, high while any task awaits acknowledge |

## Verification
The bench builds the block with five slots and a 36-bit counter. The 36-bit width makes a wrap of the system time reachable in a few cycles: the bench loads the all-ones value and reads across the wrap, and the high half then fits in four bits, which shows the shadow capture on a narrow word. Five slots leave indices 7 and 9 out of range, so ignored acknowledges and loads can be driven. Exact cycle counts taken from the loading edge place one acknowledge on the very cycle a reloaded slot expires.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    localparam logic [2:0] A_TIME_LO = 3'd0;
    localparam logic [2:0] A_TIME_HI = 3'd1;
    localparam logic [2:0] A_DLY_LO  = 3'd2;
    localparam logic [2:0] A_DLY_HI  = 3'd3;
    localparam logic [2:0] A_LOAD    = 3'd4;
    localparam logic [2:0] A_WAKE    = 3'd5;
    localparam logic [2:0] A_ACK     = 3'd6;
endpackage

// File: rtl/tdm_systime.sv
module tdm_systime #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [CNT_W-1:0] set_val,
    input  logic             snap_en,
    output logic [CNT_W-1:0] now_o,
    output logic [31:0]      shadow_o
);
    typedef struct packed {
        logic [CNT_W-1:0] now;
        logic [31:0]      shadow;
    } st_t;

    st_t st_d, st_q;
    logic [63:0] wide;

    always_comb begin
        st_d = st_q;
        wide = 64'(st_q.now);
        if (snap_en) begin
            st_d.shadow = wide[63:32];
        end
        if (set_en) begin
            st_d.now = set_val;
        end else begin
            st_d.now = st_q.now + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign now_o    = st_q.now;
    assign shadow_o = st_q.shadow;
endmodule

// File: rtl/tdm_slot.sv
module tdm_slot #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             active;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (load_en) begin
            st_d.count  = load_val;
            st_d.active = 1'b1;
        end else if (st_q.active) begin
            if (st_q.count == '0) begin
                expire_o    = 1'b1;
                st_d.active = 1'b0;
            end else begin
                st_d.count = st_q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tdm_wake.sv
module tdm_wake #(
    parameter int NUM_TASKS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TASKS-1:0] set_vec,
    input  logic [NUM_TASKS-1:0] clr_vec,
    output logic [NUM_TASKS-1:0] pend_o,
    output logic                 irq_o
);
    typedef struct packed {
        logic [NUM_TASKS-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // expiry is OR-ed in after the clear, so it wins a collision
        st_d.pend = (st_q.pend & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign irq_o  = |st_q.pend;
endmodule

// File: rtl/task_delay_mgr.sv
module task_delay_mgr #(
    parameter int NUM_TASKS = 12,
    parameter int CNT_W     = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    import tdm_pkg::*;

    typedef struct packed {
        logic [31:0] time_hi_stage;
        logic [31:0] dly_lo;
        logic [31:0] dly_hi;
    } regs_t;

    regs_t rg_d, rg_q;

    logic                 wr_time_lo, rd_time_lo, wr_load, wr_ack;
    logic [CNT_W-1:0]     sys_now;
    logic [31:0]          sys_shadow;
    logic [CNT_W-1:0]     time_set_val;
    logic [CNT_W-1:0]     dly_val;
    logic [NUM_TASKS-1:0] load_vec;
    logic [NUM_TASKS-1:0] ack_vec;
    logic [NUM_TASKS-1:0] expire_vec;
    logic [NUM_TASKS-1:0] pend_vec;
    logic [63:0]          now_wide;

    always_comb begin
        wr_time_lo = bus_sel && bus_wr && (bus_addr == A_TIME_LO);
        rd_time_lo = bus_sel && !bus_wr && (bus_addr == A_TIME_LO);
        wr_load    = bus_sel && bus_wr && (bus_addr == A_LOAD);
        wr_ack     = bus_sel && bus_wr && (bus_addr == A_ACK);
        for (int i = 0; i < NUM_TASKS; i++) begin
            load_vec[i] = wr_load && (bus_wdata == 32'(i));
            ack_vec[i]  = wr_ack && (bus_wdata == 32'(i));
        end
        time_set_val = CNT_W'({rg_q.time_hi_stage, bus_wdata});
        dly_val      = CNT_W'({rg_q.dly_hi, rg_q.dly_lo});
    end

    always_comb begin
        rg_d = rg_q;
        if (bus_sel && bus_wr) begin
            case (bus_addr)
                A_TIME_HI: rg_d.time_hi_stage = bus_wdata;
                A_DLY_LO:  rg_d.dly_lo        = bus_wdata;
                A_DLY_HI:  rg_d.dly_hi        = bus_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    tdm_systime #(.CNT_W(CNT_W)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (wr_time_lo),
        .set_val  (time_set_val),
        .snap_en  (rd_time_lo),
        .now_o    (sys_now),
        .shadow_o (sys_shadow)
    );

    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_slot
        tdm_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (load_vec[g]),
            .load_val (dly_val),
            .expire_o (expire_vec[g])
        );
    end

    tdm_wake #(.NUM_TASKS(NUM_TASKS)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (expire_vec),
        .clr_vec (ack_vec),
        .pend_o  (pend_vec),
        .irq_o   (irq)
    );

    always_comb begin
        now_wide  = 64'(sys_now);
        bus_rdata = '0;
        case (bus_addr)
            A_TIME_LO: bus_rdata = now_wide[31:0];
            A_TIME_HI: bus_rdata = sys_shadow;
            A_WAKE:    bus_rdata = 32'(pend_vec);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tdm_checker.sv
module tdm_checker #(
    parameter int NUM_TASKS = 12,
    parameter int CNT_W     = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [2:0]           bus_addr,
    input logic [31:0]          bus_wdata,
    input logic                 irq,
    input logic [CNT_W-1:0]     now,
    input logic [31:0]          shadow,
    input logic [NUM_TASKS-1:0] expire,
    input logic [NUM_TASKS-1:0] pend
);
    logic                 time_wr, time_rd, ack_wr;
    logic [NUM_TASKS-1:0] ack_only;
    logic [63:0]          now_w;

    always_comb begin
        time_wr = bus_sel && bus_wr && (bus_addr == 3'd0);
        time_rd = bus_sel && !bus_wr && (bus_addr == 3'd0);
        ack_wr  = bus_sel && bus_wr && (bus_addr == 3'd6);
        now_w   = 64'(now);
        for (int i = 0; i < NUM_TASKS; i++) begin
            ack_only[i] = ack_wr && (bus_wdata == 32'(i)) && !expire[i];
        end
    end

    a_r2_time_steps: assert property (@(posedge clk) disable iff (!rst_n)
        !time_wr |=> now == $past(now) + CNT_W'(1));

    a_r4_expiry_sets_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (expire != '0) |=> ((pend & $past(expire)) == $past(expire)));

    a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_wr) |=> irq);

    a_r7_shadow_capture: assert property (@(posedge clk) disable iff (!rst_n)
        time_rd |=> shadow == $past(now_w[63:32]));

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_only != '0) |=> ((pend & $past(ack_only)) == '0));
endmodule

bind task_delay_mgr tdm_checker #(.NUM_TASKS(NUM_TASKS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .now       (sys_now),
    .shadow    (sys_shadow),
    .expire    (expire_vec),
    .pend      (pend_vec)
);

// File: tb/task_delay_mgr_bench.sv
`timescale 1ns/1ps
module task_delay_mgr_bench;
    localparam int NT = 5;
    localparam int CW = 36;

    logic        clk = 1'b0;
    logic        rst_n, sel, wr;
    logic [2:0]  addr;
    logic [31:0] wdata, rdata;
    logic        irq;

    always #2 clk = ~clk;

    task_delay_mgr #(.NUM_TASKS(NT), .CNT_W(CW)) u_task_delay_mgr (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];

    // monitor: pops expected/actual pairs and compares
    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            logic [31:0] e, a;
            string t;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", t, a, e);
            end
        end
    end

    task automatic expect_item(string tag, logic [31:0] e);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic rd_check(logic [2:0] a, logic [31:0] e, string tag);
        sel = 1'b1; wr = 1'b0; addr = a;
        expect_item(tag, e);
        #1;
        act_q.push_back(rdata);
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic irq_check(logic e, string tag);
        expect_item(tag, {31'b0, e});
        act_q.push_back({31'b0, irq});
    endtask

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic load_slot(int idx, logic [63:0] n);
        wr_reg(3'd2, n[31:0]);
        wr_reg(3'd3, n[63:32]);
        wr_reg(3'd4, 32'(idx));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        irq_check(1'b0, "R1 irq after reset");
        rd_check(3'd1, 32'h0, "R1 shadow after reset");
        rd_check(3'd5, 32'h0, "R1 wake after reset");

        // R3 time write, R2 counting, R7 shadow
        wr_reg(3'd1, 32'h0);
        wr_reg(3'd0, 32'd100);
        rd_check(3'd0, 32'd100, "R3 time after write");
        rd_check(3'd0, 32'd101, "R2 next cycle");
        rd_check(3'd1, 32'h0, "R7 shadow small");
        idle(5);
        rd_check(3'd0, 32'd108, "R2 after idle");

        // R2 wrap at 36 bits, R7 shadow consistency
        wr_reg(3'd1, 32'hF);
        wr_reg(3'd0, 32'hFFFF_FFFF);
        rd_check(3'd0, 32'hFFFF_FFFF, "R3 max time low");
        rd_check(3'd1, 32'h0000_000F, "R7 shadow holds captured high");
        rd_check(3'd0, 32'h1, "R2 wrap to zero");
        rd_check(3'd1, 32'h0, "R7 shadow after wrap");

        // R4 delay of 3 on task 0
        load_slot(0, 64'd3);
        idle(3);
        rd_check(3'd5, 32'h0, "R4 not yet expired");
        rd_check(3'd5, 32'h1, "R4 expired at N+1");
        irq_check(1'b1, "R6 irq raised");
        wr_reg(3'd6, 32'd0);
        rd_check(3'd5, 32'h0, "R8 ack clears task 0");
        irq_check(1'b0, "R6 irq dropped");

        // R4 zero delay on task 2
        load_slot(2, 64'd0);
        rd_check(3'd5, 32'h0, "R4 zero delay same cycle");
        rd_check(3'd5, 32'h4, "R4 zero delay next cycle");

        // R8 / R6 multiple pending
        load_slot(3, 64'd0);
        idle(1);
        rd_check(3'd5, 32'hC, "R4 two pending");
        wr_reg(3'd6, 32'd2);
        rd_check(3'd5, 32'h8, "R8 only task 2 cleared");
        irq_check(1'b1, "R6 irq held with task 3 pending");
        wr_reg(3'd6, 32'd7);
        rd_check(3'd5, 32'h8, "R8 out-of-range ack ignored");
        wr_reg(3'd4, 32'd9);
        idle(2);
        rd_check(3'd5, 32'h8, "R8 out-of-range load ignored");
        wr_reg(3'd6, 32'd3);
        rd_check(3'd5, 32'h0, "R8 task 3 cleared");
        irq_check(1'b0, "R6 irq low when empty");

        // R5 reload restarts countdown
        load_slot(1, 64'd10);
        idle(5);
        load_slot(1, 64'd10);
        idle(10);
        rd_check(3'd5, 32'h0, "R5 old countdown did not fire");
        rd_check(3'd5, 32'h2, "R5 restarted countdown fired");

        // R10 load keeps wake bit, R9 ack and expiry collide
        load_slot(1, 64'd4);
        rd_check(3'd5, 32'h2, "R10 load keeps wake bit");
        idle(3);
        wr_reg(3'd6, 32'd1);
        rd_check(3'd5, 32'h2, "R9 expiry beats ack");
        wr_reg(3'd6, 32'd1);
        rd_check(3'd5, 32'h0, "R9 later ack clears");
        irq_check(1'b0, "R6 irq low at end");

        idle(3);
        done = 1;
        summary();
        $finish;
    end
endmodule